// File: doc/BRIEF.md
# Alarm-Aligned Fixed-Period Pulse Generator

This block drives up to three periodic pulse trains from a nanosecond time base. Each train has its own interval, given in nanoseconds. On every timer tick the time base moves forward by a programmable step, and each train counts that step off its remaining time. The trains do not run freely. They stay silent until software sets a start-indication bit. After that they wait for the alarm-1 match strobe. The alarm is normally set one tick before a whole-second boundary, so the first pulse of every train falls on that boundary.

Each pulse is one reference-clock cycle wide. It also raises the train's bit in an event vector, where train 1 maps to bit 7, train 2 to bit 6 and train 3 to bit 5. Pulses from trains 1 and 2 can be looped back as trigger strobes. A realignment-disable input chooses whether alarm matches after the first one restart the pulse phase. Clearing the start bit or the timer enable stops every train and sends the block back to waiting for an alarm.

Top module: `fixed_period_pulse_gen`

## Requirements
- R1: After reset, `pulse_out`, `evt_vec` and `loop_trig` are all zero.
- R2: No pulse is produced until `start_ind` and `timer_en` are both high and an `alarm_hit` then arrives at least one cycle later. An alarm seen while `start_ind` is low has no effect.
- R3: The first tick after an accepted alarm makes every train pulse. The pulse is visible in the cycle after that tick's clock edge.
- R4: When the interval is N times the step, a train pulses on every Nth tick. Cycles with `tick` low do not count.
- R5: Each train keeps the time remaining to its next pulse. A tick with remaining time no larger than `step` produces a pulse, and the remaining time is reloaded to `interval - (step - remaining)`, floored at zero. Any other tick subtracts `step`.
- R6: While trains are running with `realign_dis` low, an `alarm_hit` restarts the phase, so the next tick pulses every train. With `realign_dis` high, the alarm is ignored.
- R7: Clearing `start_ind` or `timer_en` stops all pulses at once. After both are high again, pulses resume only after a new alarm.
- R8: `evt_vec` bit 7, bit 6 and bit 5 strobe together with the pulses of trains 1, 2 and 3 (`pulse_out[0]`, `[1]`, `[2]`). Its other bits stay zero.
- R9: `loop_trig[k]` equals `pulse_out[k]` while `loop_en[k]` is high, and is zero otherwise (k = 0, 1).
- R10: A pulse is high for exactly one clock cycle per tick that produced it. There is no pulse in a cycle that follows a cycle without a tick.
- R11: An alarm that is accepted in the same cycle as a tick takes priority. That tick produces no pulse and does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_en | input | 1 | Timer enable |
| start_ind | input | 1 | Start indication that arms the trains |
| realign_dis | input | 1 | When high, alarms after the first one do not restart the phase |
| loop_en | input | 2 | Loopback enable for trains 1 and 2 |
| tick | input | 1 | Timer tick strobe |
| step | input | 10 | Nanoseconds added per tick |
| alarm_hit | input | 1 | Alarm-1 match strobe |
| interval | input | 96 | Three 32-bit intervals in ns; train 1 in the low word |
| pulse_out | output | 3 | Pulse outputs, one per train |
| evt_vec | output | 8 | Event strobes; bits 7, 6 and 5 belong to trains 1, 2 and 3 |
| loop_trig | output | 2 | Looped-back pulses of trains 1 and 2 |

## Verification
The trains run with three intervals at once: exact multiples of the step (3 and 5 ticks) and a non-multiple (2.5 ticks). The multiples show that ticks are counted correctly. The non-multiple shows that the leftover time is carried into the next reload rather than dropped. Idle cycles are placed between ticks to separate tick counting from clock counting. Alarms are applied before arming, while running with realignment allowed and forbidden, and in the same cycle as a tick. This separates phase restart, ignored alarms and alarm priority. Stop and restart through each enable input confirm that a fresh alarm is needed before pulses return.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

    // Arming sequence shared by all trains
    typedef enum logic [1:0] {
        ARM_IDLE = 2'd0,
        ARM_WAIT = 2'd1,
        ARM_RUN  = 2'd2
    } arm_state_e;

    // Highest event-vector bit; train i drives bit EVT_TOP_BIT - i
    localparam int EVT_TOP_BIT = 7;

    function automatic int evt_bit_of(input int train);
        return EVT_TOP_BIT - train;
    endfunction

endpackage

// File: rtl/fpp_arm_ctrl.sv
module fpp_arm_ctrl
    import fpp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic alarm_hit,
    input  logic realign_dis,
    output logic running,
    output logic phase_load
);
    arm_state_e state_q;

    // An alarm is accepted while waiting, or while running if realignment is allowed
    assign phase_load = enable && alarm_hit &&
                        ((state_q == ARM_WAIT) ||
                         ((state_q == ARM_RUN) && !realign_dis));
    assign running = (state_q == ARM_RUN);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state_q <= ARM_IDLE;
        end else begin
            unique case (state_q)
                ARM_IDLE: state_q <= ARM_WAIT;
                ARM_WAIT: if (alarm_hit) state_q <= ARM_RUN;
                ARM_RUN:  state_q <= ARM_RUN;
                default:  state_q <= ARM_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fpp_train.sv
module fpp_train #(
    parameter int IVL_W  = 32,
    parameter int STEP_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              running,
    input  logic              phase_load,
    input  logic              tick,
    input  logic [STEP_W-1:0] step,
    input  logic [IVL_W-1:0]  interval,
    output logic              pulse
);
    logic [IVL_W-1:0] remain_q;
    logic [IVL_W-1:0] step_ext;
    logic [IVL_W-1:0] deficit;
    logic [IVL_W-1:0] reload;
    logic             due;

    assign step_ext = IVL_W'(step);
    assign due      = (remain_q <= step_ext);
    assign deficit  = step_ext - remain_q;
    // Carry the overshoot into the next period, floored at zero
    assign reload   = (interval > deficit) ? (interval - deficit) : '0;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            remain_q <= '0;
            pulse    <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (phase_load) begin
                remain_q <= step_ext;       // next tick lands on the boundary
            end else if (running && tick) begin
                if (due) begin
                    pulse    <= 1'b1;
                    remain_q <= reload;
                end else begin
                    remain_q <= remain_q - step_ext;
                end
            end
        end
    end
endmodule

// File: rtl/fixed_period_pulse_gen.sv
module fixed_period_pulse_gen
    import fpp_pkg::*;
#(
    parameter int NUM_TRAINS = 3,
    parameter int IVL_W      = 32,
    parameter int STEP_W     = 10,
    parameter int NUM_LOOP   = 2,
    parameter int EVT_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        timer_en,
    input  logic                        start_ind,
    input  logic                        realign_dis,
    input  logic [NUM_LOOP-1:0]         loop_en,
    input  logic                        tick,
    input  logic [STEP_W-1:0]           step,
    input  logic                        alarm_hit,
    input  logic [NUM_TRAINS*IVL_W-1:0] interval,
    output logic [NUM_TRAINS-1:0]       pulse_out,
    output logic [EVT_W-1:0]            evt_vec,
    output logic [NUM_LOOP-1:0]         loop_trig
);
    logic enable;
    logic running;
    logic phase_load;

    assign enable = timer_en && start_ind;

    fpp_arm_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .alarm_hit   (alarm_hit),
        .realign_dis (realign_dis),
        .running     (running),
        .phase_load  (phase_load)
    );

    for (genvar i = 0; i < NUM_TRAINS; i++) begin : g_train
        fpp_train #(
            .IVL_W  (IVL_W),
            .STEP_W (STEP_W)
        ) u_train (
            .clk        (clk),
            .rst        (rst),
            .enable     (enable),
            .running    (running),
            .phase_load (phase_load),
            .tick       (tick),
            .step       (step),
            .interval   (interval[i*IVL_W +: IVL_W]),
            .pulse      (pulse_out[i])
        );
    end

    always_comb begin
        evt_vec = '0;
        for (int i = 0; i < NUM_TRAINS; i++) begin
            evt_vec[evt_bit_of(i)] = pulse_out[i];
        end
    end

    for (genvar k = 0; k < NUM_LOOP; k++) begin : g_loop
        assign loop_trig[k] = pulse_out[k] && loop_en[k];
    end
endmodule

// File: rtl/fpp_chk.sv
module fpp_chk #(
    parameter int NUM_TRAINS = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tick,
    input logic                  alarm_hit,
    input logic                  realign_dis,
    input logic                  start_ind,
    input logic                  timer_en,
    input logic                  running,
    input logic [NUM_TRAINS-1:0] pulse_out
);
    AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        (|pulse_out) |-> $past(tick)); // R10

    AST_ALARM_WINS: assert property (@(posedge clk) disable iff (rst)
        $past(alarm_hit && !realign_dis) |-> (pulse_out == '0)); // R11

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(!start_ind || !timer_en) |-> (pulse_out == '0)); // R7

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !running |=> (pulse_out == '0)); // R2
endmodule

bind fixed_period_pulse_gen fpp_chk #(.NUM_TRAINS(NUM_TRAINS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .alarm_hit   (alarm_hit),
    .realign_dis (realign_dis),
    .start_ind   (start_ind),
    .timer_en    (timer_en),
    .running     (running),
    .pulse_out   (pulse_out)
);

// File: tb/tb_fixed_period_pulse_gen.sv
module tb_fixed_period_pulse_gen;
    localparam int STEP = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        timer_en, start_ind, realign_dis;
    logic [1:0]  loop_en;
    logic        tick, alarm_hit;
    logic [9:0]  step;
    logic [95:0] interval;
    logic [2:0]  pulse_out;
    logic [7:0]  evt_vec;
    logic [1:0]  loop_trig;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Reference model state, built from the requirements
    int  iv [3] = '{30, 50, 25};
    int  rem [3];
    bit  m_run;

    always #5 clk = ~clk;

    fixed_period_pulse_gen dut (
        .clk(clk), .rst(rst), .timer_en(timer_en), .start_ind(start_ind),
        .realign_dis(realign_dis), .loop_en(loop_en), .tick(tick), .step(step),
        .alarm_hit(alarm_hit), .interval(interval), .pulse_out(pulse_out),
        .evt_vec(evt_vec), .loop_trig(loop_trig)
    );

    task automatic check_out(input string tag, input logic [2:0] ep);
        logic [7:0] ee;
        logic [1:0] el;
        ee = {ep[0], ep[1], ep[2], 5'b0};
        el = ep[1:0] & loop_en;
        n_chk++;
        if (pulse_out !== ep || evt_vec !== ee || loop_trig !== el) begin
            n_err++;
            $display("FAIL %s pulse=%b exp=%b evt=%h exp=%h loop=%b exp=%b",
                     tag, pulse_out, ep, evt_vec, ee, loop_trig, el);
        end
    endtask

    task automatic idle(input string tag);
        tick = 1'b0; alarm_hit = 1'b0;
        @(negedge clk);
        check_out(tag, 3'b000);
    endtask

    task automatic do_tick(input string tag);
        logic [2:0] ep;
        ep = '0;
        if (m_run) begin
            for (int i = 0; i < 3; i++) begin
                if (rem[i] <= STEP) begin
                    ep[i] = 1'b1;
                    rem[i] = rem[i] + iv[i] - STEP;
                    if (rem[i] < 0) rem[i] = 0;
                end else begin
                    rem[i] = rem[i] - STEP;
                end
            end
        end
        tick = 1'b1; alarm_hit = 1'b0;
        @(negedge clk);
        tick = 1'b0;
        check_out(tag, ep);
    endtask

    task automatic do_alarm(input string tag, input bit with_tick);
        if (timer_en && start_ind && (!m_run || !realign_dis)) begin
            m_run = 1'b1;
            for (int i = 0; i < 3; i++) rem[i] = STEP;
        end
        tick = with_tick; alarm_hit = 1'b1;
        @(negedge clk);
        tick = 1'b0; alarm_hit = 1'b0;
        check_out(tag, 3'b000);
    endtask

    task automatic t_reset();
        rst = 1'b1; timer_en = 1'b0; start_ind = 1'b0; realign_dis = 1'b0;
        loop_en = 2'b00; tick = 1'b0; alarm_hit = 1'b0; step = STEP;
        interval = {32'(iv[2]), 32'(iv[1]), 32'(iv[0])};
        m_run = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_out("R1 reset", 3'b000);
    endtask

    task automatic t_unarmed();
        timer_en = 1'b1;
        idle("R2 enable only");
        do_alarm("R2 alarm before start", 1'b0);
        repeat (4) do_tick("R2 ticks before start");
        start_ind = 1'b1;
        idle("R2 start set");
        repeat (4) do_tick("R2 ticks without alarm");
    endtask

    task automatic t_periodic();
        do_alarm("R3 alarm accepted", 1'b0);
        do_tick("R3 first boundary pulse");
        idle("R10 one cycle wide");
        for (int k = 0; k < 12; k++) begin
            do_tick("R4 R5 R8 periodic");
            if (k % 3 == 1) idle("R4 idle cycle not counted");
        end
    endtask

    task automatic t_realign();
        do_tick("R5 before realign");
        do_alarm("R6 realign alarm", 1'b0);
        do_tick("R6 all trains after realign");
        do_tick("R6 after realign");
        realign_dis = 1'b1;
        do_tick("R6 disabled pre");
        do_alarm("R6 alarm ignored when disabled", 1'b0);
        repeat (4) do_tick("R6 phase kept");
        realign_dis = 1'b0;
        do_alarm("R11 alarm with tick", 1'b1);
        do_tick("R11 pulse after priority alarm");
        repeat (3) do_tick("R11 follow-on");
    endtask

    task automatic t_loopback();
        loop_en = 2'b01;
        repeat (6) do_tick("R9 loop train 1");
        loop_en = 2'b10;
        repeat (6) do_tick("R9 loop train 2");
        loop_en = 2'b11;
        do_alarm("R9 realign for loop", 1'b0);
        do_tick("R9 both loops");
    endtask

    task automatic t_stop();
        start_ind = 1'b0; m_run = 1'b0;
        repeat (3) do_tick("R7 stopped by start clear");
        start_ind = 1'b1;
        idle("R7 restart");
        repeat (4) do_tick("R7 waits for new alarm");
        do_alarm("R7 new alarm", 1'b0);
        do_tick("R7 resumed");
        timer_en = 1'b0; m_run = 1'b0;
        repeat (3) do_tick("R7 stopped by timer enable");
        timer_en = 1'b1;
        idle("R7 timer back");
        repeat (3) do_tick("R7 still waiting");
        do_alarm("R7 alarm after enable", 1'b0);
        repeat (5) do_tick("R7 running again");
    endtask

    initial begin
        t_reset();
        t_unarmed();
        t_periodic();
        t_realign();
        t_loopback();
        t_stop();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule